// File: doc/BRIEF.md
# Function Power Management Control and Status Register

This block is the power management control and status register of one configuration-space function. Software reaches it through a dword configuration write port with a 4-bit byte-enable mask and through a read port. The register holds a two-bit device power state, a wake-request enable bit and a wake-request status bit. It passes the current power state, with a one-cycle strobe whenever that state changes, to the power control logic. When a wake request is both pending and enabled, it asks for wake signalling.

The power state field accepts only the two supported codes, full-on and the deepest low-power state. A write of either reserved code is dropped, and the state does not change. Every byte-enable mask updates exactly the bytes it selects, including masks with gaps. A second read location returns the link capabilities word. In that word, the exit-latency field follows a link-control input bit.

Top module: `pm_ctrl_reg`

## Requirements
- R1: After reset the power state is 00b (D0), the wake enable and wake status bits are 0, the state-change strobe is 0 and the wake request output is 0.
- R2: A write with byte enable bit 0 set and data bits 1:0 equal to 00b or 11b loads the power state field. When data bits 1:0 are the reserved codes 01b or 10b, the field keeps its old value, and so a reserved code never forces D0.
- R3: Each register byte changes only when its byte-enable bit is set. The wake enable (bit 8) and wake status (bit 15) bits in byte 1 update for the byte-enable masks 0x2, 0x6, 0xA, 0x3 and 0xF. A mask with bit 1 clear leaves both bits unchanged.
- R4: Wake status is set by a one-cycle event pulse only while the power state is 11b (D3); an event in D0 is ignored. Writing 1 to bit 15 with byte 1 enabled clears it. When a clear and an accepted event fall in the same cycle, the bit ends up set.
- R5: The wake request output is 1 exactly while both the wake status and wake enable bits are 1.
- R6: The state-change strobe is 1 for the single cycle after a write that loads a new power state value. It stays 0 after a write of the same value and after a reserved-code write.
- R7: With read select 0, the read data returns the power state in bits 1:0, wake enable in bit 8 and wake status in bit 15, with all other bits 0. With read select 1, it returns the link capabilities word: bits 14:12 read 111b while the link-control bit is 0 and 010b while it is 1, and all other bits read 0. Read data is valid in the same cycle as the select.

Top module port order follows below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe for this register |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_sel | input | 1 | Read location: 0 power management register, 1 link capabilities |
| cfg_rdata | output | 32 | Read data |
| pme_evt | input | 1 | Wake event pulse from the function |
| lnk_ctl_bit | input | 1 | Link-control bit that selects the exit latency |
| pwr_state | output | 2 | Current power state to the power control logic |
| state_chg | output | 1 | One-cycle strobe after the power state changes |
| pme_req | output | 1 | Wake request, active while status and enable are both set |

## Verification
Two things can happen in the same cycle: a software write-1-to-clear of the wake status, and a wake event from the function. The bench moves the device to D3, raises the event pulse on the same clock edge as a byte-1 write that sets bit 15, and then expects the status bit to read back as 1 with the wake request still high. A second case puts a power state write and a byte-1 write in the same mask with a gap (0xA, 0x3). It checks that each field changes or holds according to its own byte enable.

// File: rtl/pmcr_pkg.sv
package pmcr_pkg;
    typedef enum logic [1:0] {
        PS_D0 = 2'b00,
        PS_D1 = 2'b01,
        PS_D2 = 2'b10,
        PS_D3 = 2'b11
    } pstate_e;

    localparam int STATE_LSB   = 0;
    localparam int PME_EN_BIT  = 8;
    localparam int PME_STS_BIT = 15;
    localparam int LAT_LSB     = 12;
    localparam int LAT_W       = 3;
endpackage

// File: rtl/pm_state_ctl.sv
module pm_state_ctl
    import pmcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_code,
    output logic [1:0] state,
    output logic       chg
);
    typedef struct packed {
        logic [1:0] st;
        logic       chg;
    } st_reg_t;

    st_reg_t s_d, s_q;
    logic    code_ok;

    always_comb begin
        code_ok = (wr_code == PS_D0) || (wr_code == PS_D3);
        s_d     = s_q;
        s_d.chg = 1'b0;
        if (wr_en && code_ok) begin
            s_d.st  = wr_code;
            s_d.chg = (wr_code != s_q.st);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign state = s_q.st;
    assign chg   = s_q.chg;

    // R2: a reserved code leaves the state untouched
    a_r2_rsvd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_code == PS_D1 || wr_code == PS_D2)) |=> (state == $past(state)));

    // R6: every change of state is announced by the strobe
    a_r6_chg_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> chg);

    // R6: strobe never rises without a change of state
    a_r6_chg_real: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> (state != $past(state)));
endmodule

// File: rtl/pme_ctl.sv
module pme_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_wr,
    input  logic en_bit,
    input  logic clr_bit,
    input  logic evt,
    input  logic allow,
    output logic pme_en,
    output logic pme_sts
);
    typedef struct packed {
        logic en;
        logic sts;
    } pme_reg_t;

    pme_reg_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (byte_wr) begin
            p_d.en = en_bit;
            if (clr_bit) p_d.sts = 1'b0;
        end
        if (evt && allow) p_d.sts = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign pme_en  = p_q.en;
    assign pme_sts = p_q.sts;

    // R4: an accepted event always leaves status set, even against a clear
    a_r4_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && allow) |=> pme_sts);

    // R4: status cannot rise without an accepted event
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pme_sts) |-> $past(evt && allow));

    // R3: without a byte-1 write the enable holds
    a_r3_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_wr |=> $stable(pme_en));
endmodule

// File: rtl/link_lat.sv
module link_lat #(
    parameter int          LAT_W   = 3,
    parameter logic [2:0]  LAT_OFF = 3'b111,
    parameter logic [2:0]  LAT_ON  = 3'b010
) (
    input  logic             lnk_bit,
    output logic [LAT_W-1:0] lat
);
    always_comb begin
        lat = lnk_bit ? LAT_ON[LAT_W-1:0] : LAT_OFF[LAT_W-1:0];
    end
endmodule

// File: rtl/pm_ctrl_reg.sv
module pm_ctrl_reg
    import pmcr_pkg::*;
#(
    parameter int         DATA_W   = 32,
    parameter logic [3:0] PME_MASK = 4'b1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              cfg_rd_sel,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              pme_evt,
    input  logic              lnk_ctl_bit,
    output logic [1:0]        pwr_state,
    output logic              state_chg,
    output logic              pme_req
);
    localparam int BE_W = DATA_W / 8;

    logic             st_wr, b1_wr, allow;
    logic             en_q, sts_q;
    logic [LAT_W-1:0] lat;
    logic [DATA_W-1:0] pm_word, cap_word;
    logic             unused_wdata;

    assign st_wr = cfg_wr && cfg_be[0];
    assign b1_wr = cfg_wr && cfg_be[1];

    pm_state_ctl u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_wr),
        .wr_code (cfg_wdata[STATE_LSB+1:STATE_LSB]),
        .state   (pwr_state),
        .chg     (state_chg)
    );

    assign allow = PME_MASK[pwr_state];

    pme_ctl u_pme (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_wr (b1_wr),
        .en_bit  (cfg_wdata[PME_EN_BIT]),
        .clr_bit (cfg_wdata[PME_STS_BIT]),
        .evt     (pme_evt),
        .allow   (allow),
        .pme_en  (en_q),
        .pme_sts (sts_q)
    );

    link_lat #(.LAT_W(LAT_W)) u_lat (
        .lnk_bit (lnk_ctl_bit),
        .lat     (lat)
    );

    always_comb begin
        pm_word = '0;
        pm_word[STATE_LSB+1:STATE_LSB] = pwr_state;
        pm_word[PME_EN_BIT]            = en_q;
        pm_word[PME_STS_BIT]           = sts_q;
        cap_word = '0;
        cap_word[LAT_LSB+LAT_W-1:LAT_LSB] = lat;
        cfg_rdata = cfg_rd_sel ? cap_word : pm_word;
    end

    assign pme_req      = en_q && sts_q;
    assign unused_wdata = ^{cfg_wdata, cfg_be[BE_W-1:2]};

    // R3: writes without byte 0 leave the power state alone
    a_r3_b0_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_be[0]) |=> $stable(pwr_state));

    // R5: a new wake request is caused by an event or a byte-1 write
    a_r5_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pme_req) |-> ($past(pme_evt) || $past(cfg_wr && cfg_be[1])));

    // R4: a wake event in a state without wake support cannot raise status
    a_r4_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (pme_evt && !PME_MASK[pwr_state] && !cfg_rdata[PME_STS_BIT] && !cfg_rd_sel)
        |=> !$rose(pme_req));
endmodule

// File: tb/pm_ctrl_reg_test.sv
module pm_ctrl_reg_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_rd_sel;
    logic [31:0] cfg_rdata;
    logic        pme_evt;
    logic        lnk_ctl_bit;
    logic [1:0]  pwr_state;
    logic        state_chg;
    logic        pme_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pm_ctrl_reg uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_rd_sel(cfg_rd_sel), .cfg_rdata(cfg_rdata),
        .pme_evt(pme_evt), .lnk_ctl_bit(lnk_ctl_bit), .pwr_state(pwr_state),
        .state_chg(state_chg), .pme_req(pme_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write cycle; returns at the following negedge
    task automatic wr(input logic [3:0] be, input logic [31:0] d, input logic evt);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d; pme_evt = evt;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = '0; pme_evt = 1'b0;
    endtask

    task automatic pulse_evt();
        @(negedge clk);
        pme_evt = 1'b1;
        @(negedge clk);
        pme_evt = 1'b0;
    endtask

    function automatic logic [31:0] pmw(input logic [1:0] s, input logic en, input logic st);
        logic [31:0] w;
        w = '0; w[1:0] = s; w[8] = en; w[15] = st;
        return w;
    endfunction

    task automatic rd_pm(input string req, input logic [31:0] exp);
        cfg_rd_sel = 1'b0; #0.5;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic t_reset();
        chk("R1 state", {30'd0, pwr_state}, 32'd0);
        chk("R1 strobe", {31'd0, state_chg}, 32'd0);
        chk("R1 req", {31'd0, pme_req}, 32'd0);
        rd_pm("R1 word", 32'd0);
    endtask

    task automatic t_state();
        wr(4'h1, 32'h3, 1'b0);
        chk("R6 strobe on change", {31'd0, state_chg}, 32'd1);
        chk("R2 load D3", {30'd0, pwr_state}, 32'd3);
        @(negedge clk);
        chk("R6 strobe one cycle", {31'd0, state_chg}, 32'd0);
        wr(4'h1, 32'h1, 1'b0);
        chk("R2 reserved 01 kept D3", {30'd0, pwr_state}, 32'd3);
        chk("R6 no strobe reserved", {31'd0, state_chg}, 32'd0);
        wr(4'h1, 32'h2, 1'b0);
        chk("R2 reserved 10 kept D3", {30'd0, pwr_state}, 32'd3);
        wr(4'h1, 32'h3, 1'b0);
        chk("R6 no strobe same value", {31'd0, state_chg}, 32'd0);
        wr(4'hE, 32'h0, 1'b0);
        chk("R3 byte0 disabled", {30'd0, pwr_state}, 32'd3);
    endtask

    task automatic t_bytes();
        wr(4'h2, 32'h100, 1'b0);
        rd_pm("R3 be 0x2 sets enable", pmw(2'd3, 1'b1, 1'b0));
        wr(4'h6, 32'h0, 1'b0);
        rd_pm("R3 be 0x6 clears enable", pmw(2'd3, 1'b0, 1'b0));
        wr(4'hA, 32'h100, 1'b0);
        rd_pm("R3 be 0xA sets enable, state kept", pmw(2'd3, 1'b1, 1'b0));
        wr(4'h5, 32'h0, 1'b0);
        rd_pm("R3 be 0x5 leaves byte1", pmw(2'd0, 1'b1, 1'b0));
        wr(4'h3, 32'h3, 1'b0);
        rd_pm("R3 be 0x3 clears enable, loads D3", pmw(2'd3, 1'b0, 1'b0));
        wr(4'hF, 32'h103, 1'b0);
        rd_pm("R3 be 0xF", pmw(2'd3, 1'b1, 1'b0));
    endtask

    task automatic t_pme();
        pulse_evt();
        rd_pm("R4 event in D3 sets", pmw(2'd3, 1'b1, 1'b1));
        chk("R5 req on", {31'd0, pme_req}, 32'd1);
        wr(4'h2, 32'h8100, 1'b1);
        rd_pm("R4 clear vs event", pmw(2'd3, 1'b1, 1'b1));
        chk("R5 req stays", {31'd0, pme_req}, 32'd1);
        wr(4'h2, 32'h8000, 1'b0);
        rd_pm("R4 w1c", pmw(2'd3, 1'b0, 1'b0));
        chk("R5 req off", {31'd0, pme_req}, 32'd0);
        pulse_evt();
        chk("R5 no req without enable", {31'd0, pme_req}, 32'd0);
        wr(4'h3, 32'h8100, 1'b0);
        rd_pm("R4 D0 after clear", pmw(2'd0, 1'b1, 1'b0));
        pulse_evt();
        rd_pm("R4 event in D0 ignored", pmw(2'd0, 1'b1, 1'b0));
        chk("R5 req off in D0", {31'd0, pme_req}, 32'd0);
    endtask

    task automatic t_link();
        cfg_rd_sel = 1'b1; lnk_ctl_bit = 1'b0; #0.5;
        chk("R7 latency bit0=0", cfg_rdata, 32'h0000_7000);
        lnk_ctl_bit = 1'b1; #0.5;
        chk("R7 latency bit0=1", cfg_rdata, 32'h0000_2000);
        lnk_ctl_bit = 1'b0; #0.5;
        chk("R7 latency back", cfg_rdata, 32'h0000_7000);
        cfg_rd_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 1'b0; cfg_be = 4'h0; cfg_wdata = '0;
        cfg_rd_sel = 1'b0; pme_evt = 1'b0; lnk_ctl_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_state();
        t_bytes();
        t_pme();
        t_link();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule